// File: doc/BRIEF.md
# NOR Flash Program and Erase Engine

This block is the storage side of a serial NOR flash model. A command front end decodes the host's opcodes and hands this engine two kinds of request. The first is a single-byte program. The second is an erase of an aligned region. The engine holds the byte array and applies flash semantics to it. A program can only clear bits, unless the part is configured as byte-rewritable. An erase sets every byte of a region back to all ones. A separate read port returns the stored bytes.

A program request completes in a single clock edge. An erase is carried out as a sweep that writes one byte per clock. The `ers_busy_o` output stays high for the whole sweep, and `ers_done_o` pulses once when it ends. The same sweep fills the array with ones after reset, so the array starts erased. Both kinds of request depend on a write-enable input. The engine also reports three conditions: a program that tries to turn a 0 bit back into a 1, an erase size the part does not support, and a request rejected because write enable was low.

Top module: `nor_pe_engine`

## Requirements
- R1: During reset and for exactly DEV_BYTES cycles after it is released, `ers_busy_o` is high, with `ers_done_o` and all flag outputs low. Once `ers_busy_o` falls, every byte reads 0xFF, and no done pulse is produced for this sweep.
- R2: A program strobe with `wr_en_i` high, issued while the engine is idle, stores (old AND new) at `pgm_addr_i`. The read port returns the byte at `rd_addr_i` one clock after the address is presented.
- R3: `pgm_warn_o` pulses for one cycle, in the cycle after an accepted program, exactly when (old XOR new) AND new is nonzero.
- R4: With the parameter OVERWRITE set to 1, an accepted program stores the new byte outright, replacing the old one.
- R5: A program strobe with `wr_en_i` low leaves the array unchanged and pulses `pgm_wp_err_o` in the next cycle.
- R6: `ers_type_i` selects the erase length: 0 selects SMALL_BYTES, 1 selects MID_BYTES, 2 selects SECTOR_BYTES, and 3 selects the whole device. For types 0 to 2 the start address is `ers_addr_i` aligned down to that length. All three lengths are powers of two.
- R7: An erase writes 0xFF to every byte of the selected region and leaves every byte outside it unchanged.
- R8: An accepted erase holds `ers_busy_o` high for exactly the region length in cycles, starting in the cycle after the strobe. `ers_done_o` then pulses for one cycle with `ers_busy_o` low.
- R9: An erase strobe with `wr_en_i` low leaves the array unchanged, never raises `ers_busy_o` or `ers_done_o`, and pulses `ers_wp_err_o` in the next cycle.
- R10: `ers_unsup_o` pulses in the cycle after an erase strobe of type 0 when bit 0 of CAP_MASK is clear, or of type 1 when bit 1 is clear. The erase is still performed.
- R11: While `ers_busy_o` is high, program strobes and erase strobes are ignored. They change no data and do not alter the running sweep.
- R12: A type 3 erase always starts at address 0 and covers the whole device, whatever `ers_addr_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the fill sweep |
| wr_en_i | input | 1 | Write enable; gates program and erase |
| pgm_stb_i | input | 1 | Byte program request |
| pgm_addr_i | input | AW | Program byte address |
| pgm_data_i | input | 8 | Program data |
| pgm_warn_o | output | 1 | Pulse: program attempted to set a cleared bit |
| pgm_wp_err_o | output | 1 | Pulse: program rejected, write enable low |
| ers_stb_i | input | 1 | Erase request |
| ers_type_i | input | 2 | Erase type (see R6) |
| ers_addr_i | input | AW | Erase address, aligned down by the engine |
| ers_busy_o | output | 1 | Sweep in progress |
| ers_done_o | output | 1 | Pulse: erase finished |
| ers_unsup_o | output | 1 | Pulse: erase size not in capability mask |
| ers_wp_err_o | output | 1 | Pulse: erase rejected, write enable low |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 8 | Read data, one cycle latency |

## Verification
The assertions check the following on every cycle:
- No program write reaches the array during a sweep.
- Outside overwrite mode, a program write never sets a bit that was clear.
- The sweep cursor never passes the region end.
- A done pulse follows only the falling edge of busy.
- A rejected erase never starts a sweep.
- The unsupported-size flag follows only an accepted strobe.

Only the bench scenarios can show the effects that depend on data. These are: the exact region that gets cleared and the bytes around it that survive, the alignment of odd addresses, the busy length for each type, and the initial all-ones contents. They also cover strobes ignored in the middle of a sweep and the different results of AND mode and overwrite mode under the same stimulus.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;

  typedef enum logic [1:0] {
    ERS_SMALL  = 2'd0,
    ERS_MID    = 2'd1,
    ERS_SECTOR = 2'd2,
    ERS_CHIP   = 2'd3
  } ers_kind_e;

  // Region length in bytes chosen by erase kind
  function automatic int unsigned region_len(ers_kind_e k, int unsigned small_b,
                                             int unsigned mid_b, int unsigned sect_b,
                                             int unsigned dev_b);
    case (k)
      ERS_SMALL:  return small_b;
      ERS_MID:    return mid_b;
      ERS_SECTOR: return sect_b;
      default:    return dev_b;
    endcase
  endfunction

  // Start of region: whole-device erase begins at zero, others align down
  function automatic int unsigned region_base(ers_kind_e k, int unsigned addr,
                                              int unsigned len);
    if (k == ERS_CHIP) return 0;
    return addr & ~(len - 1);
  endfunction

  // NOR merge: bits can only be cleared unless overwrite is allowed
  function automatic logic [7:0] merge_byte(logic [7:0] old_b, logic [7:0] new_b,
                                            bit overwrite);
    return overwrite ? new_b : (old_b & new_b);
  endfunction

  // True when the new byte asks for a 0 -> 1 transition
  function automatic logic raises_bit(logic [7:0] old_b, logic [7:0] new_b);
    return |((old_b ^ new_b) & new_b);
  endfunction

endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ers_we_i,
  input  logic [AW-1:0] ers_addr_i,
  input  logic          pgm_we_i,
  input  logic [AW-1:0] pgm_addr_i,
  input  logic [7:0]    pgm_wdata_i,
  input  logic [AW-1:0] peek_addr_i,
  output logic [7:0]    peek_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic [7:0] mem [DEPTH];

  // Erase sweep and program never collide: the sequencer owns the array while busy
  always_ff @(posedge clk) begin
    if (ers_we_i)      mem[ers_addr_i] <= 8'hFF;
    else if (pgm_we_i) mem[pgm_addr_i] <= pgm_wdata_i;
    rd_data_o <= mem[rd_addr_i];
  end

  assign peek_data_o = mem[peek_addr_i];

  p_single_writer_r11: assert property (@(posedge clk) !(ers_we_i && pgm_we_i))
    else $error("array written by sweep and program together");

endmodule

// File: rtl/nor_prog_unit.sv
module nor_prog_unit
  import nor_pe_pkg::*;
#(
  parameter bit OVERWRITE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  logic       wr_en_i,
  input  logic       busy_i,
  input  logic [7:0] old_i,
  input  logic [7:0] new_i,
  output logic       we_o,
  output logic [7:0] wdata_o,
  output logic       warn_o,
  output logic       wp_err_o
);

  logic taken_w;
  logic refused_w;

  assign taken_w   = stb_i && !busy_i && wr_en_i;
  assign refused_w = stb_i && !busy_i && !wr_en_i;
  assign we_o      = taken_w;
  assign wdata_o   = merge_byte(old_i, new_i, OVERWRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_o   <= 1'b0;
      wp_err_o <= 1'b0;
    end else begin
      warn_o   <= taken_w && raises_bit(old_i, new_i);
      wp_err_o <= refused_w;
    end
  end

  generate
    if (!OVERWRITE) begin : g_and_mode
      p_no_bit_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ((wdata_o & ~old_i) == 8'h00))
        else $error("program raised a cleared bit");
    end else begin : g_ovw_mode
      p_ovw_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (wdata_o == new_i))
        else $error("overwrite mode did not store new byte");
    end
  endgenerate

  p_warn_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && ((new_i & ~old_i) != 8'h00)) |=> warn_o)
    else $error("missing 0->1 warning");

  p_refuse_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err_o |-> $past(stb_i && !wr_en_i))
    else $error("program error flag without refused strobe");

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_pe_pkg::*;
#(
  parameter int unsigned SMALL_B  = 16,
  parameter int unsigned MID_B    = 64,
  parameter int unsigned SECT_B   = 128,
  parameter int unsigned DEV_B    = 1024,
  parameter logic [1:0]  CAP_MASK = 2'b01,
  localparam int unsigned AW      = $clog2(DEV_B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          stb_i,
  input  ers_kind_e     kind_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          unsup_o,
  output logic          wp_err_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o
);

  logic [AW-1:0] cur_q;
  logic [AW-1:0] last_q;
  logic          init_q;
  int unsigned   len_w;
  int unsigned   base_w;
  logic          accept_w;
  logic          unsup_w;

  always_comb begin
    len_w    = region_len(kind_i, SMALL_B, MID_B, SECT_B, DEV_B);
    base_w   = region_base(kind_i, 32'(addr_i), len_w);
    accept_w = stb_i && !busy_o;
    unsup_w  = ((kind_i == ERS_SMALL) && !CAP_MASK[0]) ||
               ((kind_i == ERS_MID)   && !CAP_MASK[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b1;
      cur_q    <= '0;
      last_q   <= AW'(DEV_B - 1);
      init_q   <= 1'b1;
      done_o   <= 1'b0;
      unsup_o  <= 1'b0;
      wp_err_o <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      unsup_o  <= 1'b0;
      wp_err_o <= 1'b0;
      if (busy_o) begin
        if (cur_q == last_q) begin
          busy_o <= 1'b0;
          done_o <= !init_q;
          init_q <= 1'b0;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end else if (accept_w) begin
        unsup_o <= unsup_w;
        if (wr_en_i) begin
          busy_o <= 1'b1;
          cur_q  <= AW'(base_w);
          last_q <= AW'(base_w + len_w - 1);
        end else begin
          wp_err_o <= 1'b1;
        end
      end
    end
  end

  assign we_o    = busy_o;
  assign waddr_o = cur_q;

  p_cursor_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cur_q <= last_q))
    else $error("sweep cursor beyond region end");

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)))
    else $error("done without a finished sweep");

  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !busy_o && !wr_en_i) |=> (!busy_o && wp_err_o))
    else $error("erase started without write enable");

  p_unsup_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> $past(stb_i && !busy_o))
    else $error("unsupported flag without accepted strobe");

endmodule

// File: rtl/nor_pe_engine.sv
module nor_pe_engine
  import nor_pe_pkg::*;
#(
  parameter int unsigned SMALL_BYTES  = 16,
  parameter int unsigned MID_BYTES    = 64,
  parameter int unsigned SECTOR_BYTES = 128,
  parameter int unsigned SECTOR_COUNT = 8,
  parameter logic [1:0]  CAP_MASK     = 2'b01,
  parameter bit          OVERWRITE    = 1'b0,
  localparam int unsigned DEV_BYTES   = SECTOR_BYTES * SECTOR_COUNT,
  localparam int unsigned AW          = $clog2(DEV_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          pgm_stb_i,
  input  logic [AW-1:0] pgm_addr_i,
  input  logic [7:0]    pgm_data_i,
  output logic          pgm_warn_o,
  output logic          pgm_wp_err_o,
  input  logic          ers_stb_i,
  input  logic [1:0]    ers_type_i,
  input  logic [AW-1:0] ers_addr_i,
  output logic          ers_busy_o,
  output logic          ers_done_o,
  output logic          ers_unsup_o,
  output logic          ers_wp_err_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic          sweep_we;
  logic [AW-1:0] sweep_addr;
  logic          pgm_we;
  logic [7:0]    pgm_wdata;
  logic [7:0]    old_byte;

  nor_erase_seq #(
    .SMALL_B (SMALL_BYTES),
    .MID_B   (MID_BYTES),
    .SECT_B  (SECTOR_BYTES),
    .DEV_B   (DEV_BYTES),
    .CAP_MASK(CAP_MASK)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .stb_i   (ers_stb_i),
    .kind_i  (ers_kind_e'(ers_type_i)),
    .addr_i  (ers_addr_i),
    .busy_o  (ers_busy_o),
    .done_o  (ers_done_o),
    .unsup_o (ers_unsup_o),
    .wp_err_o(ers_wp_err_o),
    .we_o    (sweep_we),
    .waddr_o (sweep_addr)
  );

  nor_prog_unit #(
    .OVERWRITE(OVERWRITE)
  ) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_i   (pgm_stb_i),
    .wr_en_i (wr_en_i),
    .busy_i  (ers_busy_o),
    .old_i   (old_byte),
    .new_i   (pgm_data_i),
    .we_o    (pgm_we),
    .wdata_o (pgm_wdata),
    .warn_o  (pgm_warn_o),
    .wp_err_o(pgm_wp_err_o)
  );

  nor_array #(
    .DEPTH(DEV_BYTES)
  ) u_arr (
    .clk        (clk),
    .ers_we_i   (sweep_we),
    .ers_addr_i (sweep_addr),
    .pgm_we_i   (pgm_we),
    .pgm_addr_i (pgm_addr_i),
    .pgm_wdata_i(pgm_wdata),
    .peek_addr_i(pgm_addr_i),
    .peek_data_o(old_byte),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  p_busy_blocks_pgm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ers_busy_o |-> !pgm_we)
    else $error("program accepted during sweep");

  p_done_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ers_done_o |-> !ers_wp_err_o)
    else $error("done coincides with rejection");

endmodule

// File: tb/test_nor_pe_engine.sv
module test_nor_pe_engine;

  localparam int SB = 16, MB = 64, SECB = 128, SCNT = 8;
  localparam int DEV = SECB * SCNT;
  localparam int AW = $clog2(DEV);
  localparam logic [1:0] CAP = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic pgm_stb = 1'b0;
  logic [AW-1:0] pgm_addr = '0;
  logic [7:0] pgm_data = '0;
  logic ers_stb = 1'b0;
  logic [1:0] ers_type = '0;
  logic [AW-1:0] ers_addr = '0;
  logic [AW-1:0] rd_addr = '0;

  logic warn, pwp, busy, done, unsup, ewp;
  logic [7:0] rd_data;
  logic warn_o2, pwp_o2, busy_o2, done_o2, unsup_o2, ewp_o2;
  logic [7:0] rd_data_o2;

  always #2.5 clk = ~clk;

  nor_pe_engine #(.SMALL_BYTES(SB), .MID_BYTES(MB), .SECTOR_BYTES(SECB),
    .SECTOR_COUNT(SCNT), .CAP_MASK(CAP), .OVERWRITE(1'b0)) i_nor_pe_engine (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
    .pgm_stb_i(pgm_stb), .pgm_addr_i(pgm_addr), .pgm_data_i(pgm_data),
    .pgm_warn_o(warn), .pgm_wp_err_o(pwp),
    .ers_stb_i(ers_stb), .ers_type_i(ers_type), .ers_addr_i(ers_addr),
    .ers_busy_o(busy), .ers_done_o(done), .ers_unsup_o(unsup), .ers_wp_err_o(ewp),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  nor_pe_engine #(.SMALL_BYTES(SB), .MID_BYTES(MB), .SECTOR_BYTES(SECB),
    .SECTOR_COUNT(SCNT), .CAP_MASK(2'b11), .OVERWRITE(1'b1)) i_nor_pe_engine_ow (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
    .pgm_stb_i(pgm_stb), .pgm_addr_i(pgm_addr), .pgm_data_i(pgm_data),
    .pgm_warn_o(warn_o2), .pgm_wp_err_o(pwp_o2),
    .ers_stb_i(ers_stb), .ers_type_i(ers_type), .ers_addr_i(ers_addr),
    .ers_busy_o(busy_o2), .ers_done_o(done_o2), .ers_unsup_o(unsup_o2), .ers_wp_err_o(ewp_o2),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data_o2));

  logic [7:0] mem_m [DEV];
  logic [7:0] mem_o [DEV];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] k);
    if (k == 2'd0) return SB;
    if (k == 2'd1) return MB;
    if (k == 2'd2) return SECB;
    return DEV;
  endfunction

  function automatic int bbase(input logic [1:0] k, input int a);
    if (k == 2'd3) return 0;
    return (a / blen(k)) * blen(k);
  endfunction

  task automatic prog(input int a, input logic [7:0] d);
    logic [7:0] old;
    bit exp_w;
    old = mem_m[a];
    pgm_addr = AW'(a); pgm_data = d; pgm_stb = 1'b1;
    @(negedge clk);
    pgm_stb = 1'b0;
    if (wr_en) begin
      exp_w = ((old ^ d) & d) != 8'h00;
      check(warn == exp_w, "R3 warn", int'(warn), int'(exp_w));
      check(pwp == 1'b0, "R5 no refuse", int'(pwp), 0);
      mem_m[a] = old & d;
      mem_o[a] = d;
    end else begin
      check(pwp == 1'b1, "R5 refuse flag", int'(pwp), 1);
      check(warn == 1'b0, "R5 no warn", int'(warn), 0);
    end
  endtask

  task automatic erase(input logic [1:0] k, input int a);
    int len, base, cnt;
    bit exp_u, ok_we;
    len = blen(k); base = bbase(k, a);
    exp_u = ((k == 2'd0) && !CAP[0]) || ((k == 2'd1) && !CAP[1]);
    ok_we = wr_en;
    ers_type = k; ers_addr = AW'(a); ers_stb = 1'b1;
    @(negedge clk);
    ers_stb = 1'b0;
    check(unsup == exp_u, "R10 unsupported flag", int'(unsup), int'(exp_u));
    check(unsup_o2 == 1'b0, "R10 full capability", int'(unsup_o2), 0);
    check(ewp == !ok_we, "R9 erase refuse flag", int'(ewp), int'(!ok_we));
    if (ok_we) begin
      cnt = 0;
      while (busy) begin
        cnt++;
        @(negedge clk);
      end
      check(cnt == len, "R8 busy length", cnt, len);
      check(done == 1'b1, "R8 done pulse", int'(done), 1);
      for (int i = base; i < base + len; i++) begin
        mem_m[i] = 8'hFF;
        mem_o[i] = 8'hFF;
      end
    end else begin
      check(busy == 1'b0, "R9 no busy", int'(busy), 0);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R9 no sweep", int'({busy, done}), 0);
    end
  endtask

  task automatic readback(input string req);
    int bad_m, bad_o, fa;
    logic [7:0] fv, fe;
    bad_m = 0; bad_o = 0; fa = 0; fv = 0; fe = 0;
    for (int a = 0; a < DEV; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      if (rd_data !== mem_m[a]) begin
        if (bad_m == 0) begin fa = a; fv = rd_data; fe = mem_m[a]; end
        bad_m++;
      end
      if (rd_data_o2 !== mem_o[a]) bad_o++;
    end
    check(bad_m == 0, {req, " array contents"}, int'(fv), int'(fe));
    if (bad_m != 0) $display("  first mismatch at address %0d, %0d bytes differ", fa, bad_m);
    check(bad_o == 0, {req, " R4 overwrite array contents"}, bad_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    bit busy_seen_done;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEV; i++) begin mem_m[i] = 8'hFF; mem_o[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && done == 1'b0 && unsup == 1'b0 && ewp == 1'b0 && pwp == 1'b0 && warn == 1'b0,
          "R1 reset state", int'({busy, done, unsup, ewp, pwp, warn}), 6'b100000);
    rst_n = 1'b1;
    cnt = 0; busy_seen_done = 1'b0;
    while (busy) begin
      cnt++;
      if (done) busy_seen_done = 1'b1;
      @(negedge clk);
    end
    check(cnt == DEV, "R1 fill sweep length", cnt, DEV);
    check(!busy_seen_done && done == 1'b0, "R1 no done for fill", int'(done), 0);
    readback("R1 initial all ones");

    // R2/R3: AND semantics and 0->1 warning
    wr_en = 1'b1;
    prog(5, 8'hA5);
    prog(5, 8'h5A);
    rd_addr = AW'(5);
    @(negedge clk);
    check(rd_data == 8'h00, "R2 AND merge read", int'(rd_data), 8'h00);
    check(rd_data_o2 == 8'h5A, "R4 overwrite read", int'(rd_data_o2), 8'h5A);
    prog(5, 8'hFF);
    prog(6, 8'hF0);

    // R5: program refused without write enable
    wr_en = 1'b0;
    prog(7, 8'h00);
    rd_addr = AW'(7);
    @(negedge clk);
    check(rd_data == 8'hFF, "R5 refused program left byte", int'(rd_data), 8'hFF);

    // R9: erase refused
    erase(2'd2, 5);
    readback("R9 refused erase");

    // R6/R7/R10: scatter zeros then erase each kind at unaligned addresses
    wr_en = 1'b1;
    for (int a = 0; a < DEV; a += 3) prog(a, 8'h00);
    erase(2'd0, 37);
    erase(2'd1, 200);
    erase(2'd2, 300);
    readback("R6 R7 region erase");

    // R11: strobes ignored while busy
    for (int a = 0; a < DEV; a += 5) prog(a, 8'h0F);
    ers_type = 2'd2; ers_addr = AW'(10); ers_stb = 1'b1;
    @(negedge clk);
    ers_stb = 1'b0;
    cnt = 1;
    @(negedge clk); cnt++;
    pgm_addr = AW'(900); pgm_data = 8'h00; pgm_stb = 1'b1;
    ers_type = 2'd3; ers_stb = 1'b1;
    @(negedge clk); cnt++;
    check(pwp == 1'b0 && warn == 1'b0, "R11 program strobe ignored flags", int'({pwp, warn}), 0);
    pgm_stb = 1'b0; ers_stb = 1'b0;
    while (busy) begin cnt++; @(negedge clk); end
    check(cnt - 1 == SECB, "R11 sweep length unchanged", cnt - 1, SECB);
    for (int i = 0; i < SECB; i++) begin mem_m[i] = 8'hFF; mem_o[i] = 8'hFF; end
    readback("R11 ignored strobes");

    // R12: whole-device erase from a nonzero address
    erase(2'd3, 777);
    readback("R12 chip erase");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      wr_en = ($urandom_range(9) != 0);
      if ($urandom_range(11) == 0) begin
        logic [1:0] k;
        k = 2'($urandom_range(2));
        erase(k, $urandom_range(DEV - 1));
      end else begin
        prog($urandom_range(DEV - 1), 8'($urandom_range(255)));
      end
      if (n % 100 == 99) readback("R2 R7 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule